// File: doc/BRIEF.md
# Raster Sync and Blanking Generator

This block produces the line and field timing for a monochrome camera. It runs from a master clock at 1212 times the line rate and halves it into a pixel clock, so a line of the default build spans 606 pixel periods. A pixel counter and a line counter walk through the raster. A combinational decoder turns their values into five timing outputs: horizontal drive, vertical drive, composite sync with equalizing and serration pulses, composite blanking, and a field flag. The outputs are registered once per pixel period.

A standard select chooses between a 525-line and a 625-line raster. A scan select chooses between interlaced and progressive operation. In interlaced operation the frame is split into two fields. The second field starts halfway through a line. In progressive operation every field has the same whole number of lines, and a length select sets that number to 262 or 263 lines (or 312 or 313 for the 625-line standard). A synchronous reset sends both counters back to line 1, pixel 0.

Top module: `raster_sync_gen`

## Requirements
- R1: While `rst` is high, every output is low. On release, the pixel count is 0 and the line count is 1.
- R2: `mck` toggles on every master clock, starting low after reset. The counters advance, and the registered outputs may change, only on the master edges where `mck` goes low. One line is `LINE_MCK` pixel periods (606 by default). Each output reflects the counter state of the previous pixel period.
- R3: With `prog_en`=0, the line counter wraps after 525 lines (`std_sel`=0) or 625 lines (`std_sel`=1). `odd_field` is high from line 1, pixel 0 until the midpoint of line 263 (or 313). It is low from that midpoint to the end of the frame.
- R4: With `prog_en`=1, the field has 262 or 263 lines (525 standard) or 312 or 313 lines (625 standard), where `long_field`=1 selects the longer value. `odd_field` stays high.
- R5: `hdrive` is high for the first `HSYNC_W` (45) pixels of every line. Outside the vertical interval, `csync` is high for the same span.
- R6: The equalizing regions are 6 half-lines (525 standard) or 5 half-lines (625 standard), counted from each field start. One region lies before the vertical sync region and one after it. In both, `csync` is high for the first `EQ_W` (22) pixels of every half-line.
- R7: In the vertical sync region (the next 6 or 5 half-lines after the first equalizing region), `csync` is high for the first half-line minus `HSYNC_W` pixels of each half-line.
- R8: `vdrive` is high for the first `VD_HALVES` (6) half-lines after each field start. The even field starts at the line midpoint.
- R9: `cblank` is the OR of a horizontal window and a vertical window. The horizontal window covers pixels below 114 (525 standard) or 104 (625 standard). The vertical window covers the first 20 or 25 lines of the field, counted in half-lines from the field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 1212 times the line rate |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| prog_en | input | 1 | 1 = progressive (non-interlaced) scan |
| long_field | input | 1 | In progressive scan, 1 = one extra line per field |
| mck | output | 1 | Pixel clock, master clock divided by two |
| hdrive | output | 1 | Horizontal drive pulse |
| vdrive | output | 1 | Vertical drive pulse |
| csync | output | 1 | Composite sync, high during sync tips |
| cblank | output | 1 | Composite blanking |
| odd_field | output | 1 | High during the odd field |

## Verification
Two events can land on the same pixel: the line counter wrapping to line 1, and the sync decoder switching from ordinary line sync to 22-pixel equalizing pulses at the field start. In the even field there is a second such case. The half-line crossing inside a single line starts the field, drops the field flag, raises vertical drive and begins equalizing, all in one pixel. Whole frames are run in both standards and in both scan modes to reach these cases. A behavioural model compares every output on every master clock. The model computes each pixel's position from absolute time since the field start, not from the line and pixel counters. Vertical-drive and field-flag rise spacings are also measured to check the field and frame lengths.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int LINE_W = 10;
    localparam int HIDX_W = LINE_W + 1;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } tv_std_e;

    typedef struct packed {
        logic hdrive;
        logic vdrive;
        logic csync;
        logic cblank;
        logic odd;
    } raster_out_t;

    function automatic logic [LINE_W-1:0] frame_lines(tv_std_e s);
        return (s == STD_625) ? LINE_W'(625) : LINE_W'(525);
    endfunction

    function automatic logic [LINE_W-1:0] field_lines(tv_std_e s, logic lng);
        logic [LINE_W-1:0] base;
        base = (s == STD_625) ? LINE_W'(312) : LINE_W'(262);
        return lng ? base + LINE_W'(1) : base;
    endfunction

    function automatic logic [HIDX_W-1:0] eq_halves(tv_std_e s);
        return (s == STD_625) ? HIDX_W'(5) : HIDX_W'(6);
    endfunction

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
    parameter int LINE_MCK = 606,
    localparam int PIX_W = $clog2(LINE_MCK)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             tick,
    output logic [PIX_W-1:0] pix,
    output logic             line_end
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            pix   <= '0;
        end else begin
            phase <= ~phase;
            if (phase) begin
                pix <= line_end ? '0 : pix + PIX_W'(1);
            end
        end
    end

    assign tick     = phase;
    assign line_end = phase && (pix == PIX_W'(LINE_MCK - 1));

    // R2
    pix_range_chk: assert property (@(posedge clk) disable iff (rst)
        pix <= PIX_W'(LINE_MCK - 1));
    // R2
    pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pix));
    // R2
    pix_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        line_end |=> pix == '0);

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  tv_std_e           std,
    input  logic              prog,
    input  logic              lng,
    output logic [LINE_W-1:0] line
);
    logic [LINE_W-1:0] limit;

    always_comb begin
        limit = prog ? field_lines(std, lng) : frame_lines(std);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= LINE_W'(1);
        end else if (line_end) begin
            line <= (line >= limit) ? LINE_W'(1) : line + LINE_W'(1);
        end
    end

    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(line));
    // R3
    line_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        line != '0);

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
#(
    parameter int LINE_MCK  = 606,
    parameter int HSYNC_W   = 45,
    parameter int EQ_W      = 22,
    parameter int HBLK_A    = 114,
    parameter int HBLK_B    = 104,
    parameter int VD_HALVES = 6,
    parameter int VBL_A     = 20,
    parameter int VBL_B     = 25,
    localparam int PIX_W = $clog2(LINE_MCK),
    localparam int HALF  = LINE_MCK / 2
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  tv_std_e           std,
    input  logic              prog,
    output raster_out_t       q
);
    logic              second;
    logic [PIX_W-1:0]  p;
    logic [LINE_W-1:0] mid_line;
    logic              even;
    logic [HIDX_W-1:0] hidx, e1, e2, e3, vbl_h;
    logic              in_pre, in_vs, in_post;
    logic [PIX_W-1:0]  hb;

    always_comb begin
        second   = pix >= PIX_W'(HALF);
        p        = second ? pix - PIX_W'(HALF) : pix;
        mid_line = (frame_lines(std) >> 1) + LINE_W'(1);
        even     = !prog && ((line > mid_line) || (line == mid_line && second));
        hidx     = even ? ({line - mid_line, second} - HIDX_W'(1))
                        : {line - LINE_W'(1), second};
        e1       = eq_halves(std);
        e2       = e1 << 1;
        e3       = e2 + e1;
        in_pre   = hidx < e1;
        in_vs    = !in_pre && (hidx < e2);
        in_post  = !(hidx < e2) && (hidx < e3);
        hb       = (std == STD_625) ? PIX_W'(HBLK_B) : PIX_W'(HBLK_A);
        vbl_h    = (std == STD_625) ? HIDX_W'(2 * VBL_B) : HIDX_W'(2 * VBL_A);

        q.hdrive = pix < PIX_W'(HSYNC_W);
        q.vdrive = hidx < HIDX_W'(VD_HALVES);
        if (in_pre || in_post) begin
            q.csync = p < PIX_W'(EQ_W);
        end else if (in_vs) begin
            q.csync = p < PIX_W'(HALF - HSYNC_W);
        end else begin
            q.csync = pix < PIX_W'(HSYNC_W);
        end
        q.cblank = (pix < hb) || (hidx < vbl_h);
        q.odd    = !even;
    end

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import raster_pkg::*;
#(
    parameter int LINE_MCK  = 606,
    parameter int HSYNC_W   = 45,
    parameter int EQ_W      = 22,
    parameter int HBLK_A    = 114,
    parameter int HBLK_B    = 104,
    parameter int VD_HALVES = 6,
    parameter int VBL_A     = 20,
    parameter int VBL_B     = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic std_sel,
    input  logic prog_en,
    input  logic long_field,
    output logic mck,
    output logic hdrive,
    output logic vdrive,
    output logic csync,
    output logic cblank,
    output logic odd_field
);
    localparam int PIX_W = $clog2(LINE_MCK);

    tv_std_e           std;
    logic              tick, line_end;
    logic [PIX_W-1:0]  pix;
    logic [LINE_W-1:0] line;
    raster_out_t       dec, q;

    assign std = tv_std_e'(std_sel);

    raster_hcount #(.LINE_MCK(LINE_MCK)) u_h (
        .clk(clk), .rst(rst), .tick(tick), .pix(pix), .line_end(line_end)
    );

    raster_vcount u_v (
        .clk(clk), .rst(rst), .line_end(line_end), .std(std),
        .prog(prog_en), .lng(long_field), .line(line)
    );

    raster_decode #(
        .LINE_MCK(LINE_MCK), .HSYNC_W(HSYNC_W), .EQ_W(EQ_W),
        .HBLK_A(HBLK_A), .HBLK_B(HBLK_B), .VD_HALVES(VD_HALVES),
        .VBL_A(VBL_A), .VBL_B(VBL_B)
    ) u_d (
        .pix(pix), .line(line), .std(std), .prog(prog_en), .q(dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (tick) begin
            q <= dec;
        end
    end

    assign mck       = tick;
    assign hdrive    = q.hdrive;
    assign vdrive    = q.vdrive;
    assign csync     = q.csync;
    assign cblank    = q.cblank;
    assign odd_field = q.odd;

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(q));
    // R9
    sync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        csync |-> cblank);
    // R9
    vd_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        vdrive |-> cblank);
    // R4
    prog_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_en && odd_field) |=> (odd_field || !prog_en));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q == '0 && !mck));

endmodule

// File: tb/sim_raster_sync_gen.sv
module sim_raster_sync_gen;
    localparam int LM = 40, HS = 6, EQ = 3, HBA = 12, HBB = 10;
    localparam int VDH = 6, VBA = 20, VBB = 25;

    logic clk = 1'b0, rst = 1'b1, std_s = 1'b0, prog_s = 1'b0, lng_s = 1'b0;
    logic mck, hdrive, vdrive, csync, cblank, odd_field;
    int vec = 0, mis = 0, cyc = 0;

    always #5 clk = ~clk;

    raster_sync_gen #(.LINE_MCK(LM), .HSYNC_W(HS), .EQ_W(EQ), .HBLK_A(HBA),
        .HBLK_B(HBB), .VD_HALVES(VDH), .VBL_A(VBA), .VBL_B(VBB)) u0 (
        .clk(clk), .rst(rst), .std_sel(std_s), .prog_en(prog_s),
        .long_field(lng_s), .mck(mck), .hdrive(hdrive), .vdrive(vdrive),
        .csync(csync), .cblank(cblank), .odd_field(odd_field));

    // behavioural reference: position from absolute time in the field
    int m_ph = 0, m_pix = 0, m_line = 1;
    logic e_mck = 0, e_hd = 0, e_vd = 0, e_sy = 0, e_bl = 0, e_od = 0;
    string sync_tag = "R5";

    task automatic model_eval(input int pix, input int line);
        int frame, fl, abs_t, halfF, t, hi, p, E;
        bit even;
        frame = std_s ? 625 : 525;
        abs_t = (line - 1) * LM + pix;
        halfF = frame * LM / 2;
        even  = !prog_s && (abs_t >= halfF);
        t     = even ? abs_t - halfF : abs_t;
        hi    = t / (LM / 2);
        p     = t % (LM / 2);
        E     = std_s ? 5 : 6;
        e_hd  = pix < HS;
        e_vd  = hi < VDH;
        if (hi < E || (hi >= 2 * E && hi < 3 * E)) begin
            e_sy = p < EQ; sync_tag = "R6";
        end else if (hi < 2 * E) begin
            e_sy = p < (LM / 2 - HS); sync_tag = "R7";
        end else begin
            e_sy = pix < HS; sync_tag = "R5";
        end
        e_bl = (pix < (std_s ? HBB : HBA)) || (hi < 2 * (std_s ? VBB : VBA));
        e_od = !even;
    endtask

    always @(posedge clk) begin
        int lim;
        cyc++;
        if (rst) begin
            m_ph = 0; m_pix = 0; m_line = 1;
            {e_hd, e_vd, e_sy, e_bl, e_od} = '0;
        end else begin
            if (m_ph == 1) begin
                model_eval(m_pix, m_line);
                lim = prog_s ? (std_s ? (lng_s ? 313 : 312) : (lng_s ? 263 : 262))
                             : (std_s ? 625 : 525);
                m_pix++;
                if (m_pix == LM) begin
                    m_pix = 0;
                    m_line = (m_line >= lim) ? 1 : m_line + 1;
                end
            end
            m_ph = 1 - m_ph;
        end
        e_mck = (m_ph == 1);
    end

    task automatic chk(input string req, input string nm, input logic a, input logic e);
        if (a !== e) begin
            mis++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, nm, cyc, a, e);
        end
    endtask

    // per-clock comparison and rise-spacing monitors
    logic prev_vd = 0, prev_od = 0;
    int vd_last = 0, vd_prev = 0, vd_n = 0, od_last = 0, od_prev = 0, od_n = 0;
    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            vec++;
            chk("R2", "mck", mck, e_mck);
            chk("R5", "hdrive", hdrive, e_hd);
            chk("R8", "vdrive", vdrive, e_vd);
            chk(sync_tag, "csync", csync, e_sy);
            chk("R9", "cblank", cblank, e_bl);
            chk(prog_s ? "R4" : "R3", "odd_field", odd_field, e_od);
        end
        if (vdrive && !prev_vd) begin vd_prev = vd_last; vd_last = cyc; vd_n++; end
        if (odd_field && !prev_od) begin od_prev = od_last; od_last = cyc; od_n++; end
        prev_vd = vdrive; prev_od = odd_field;
    end

    task automatic scenario(input logic s, input logic pr, input logic lg, input int clocks);
        @(negedge clk);
        rst = 1'b1; std_s = s; prog_s = pr; lng_s = lg;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        vec++;
        if ({mck, hdrive, vdrive, csync, cblank, odd_field} !== 6'b0) begin
            mis++;
            $display("FAIL R1 reset outputs: actual %b expected 000000",
                     {mck, hdrive, vdrive, csync, cblank, odd_field});
        end
        vd_n = 0; od_n = 0;
        rst = 1'b0;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic spacing(input string req, input string nm, input int n, input int d, input int exp_d);
        vec++;
        if (n < 2 || d != exp_d) begin
            mis++;
            $display("FAIL %s %s spacing: actual %0d (rises %0d) expected %0d", req, nm, d, n, exp_d);
        end
    endtask

    initial begin
        cmp_on = 1;
        // interlaced 525
        scenario(1'b0, 1'b0, 1'b0, 525 * LM * 2 + 200);
        spacing("R8", "vdrive", vd_n, vd_last - vd_prev, 525 * LM);
        spacing("R3", "odd_field", od_n, od_last - od_prev, 525 * LM * 2);
        // interlaced 625
        scenario(1'b1, 1'b0, 1'b0, 625 * LM * 2 + 200);
        spacing("R8", "vdrive", vd_n, vd_last - vd_prev, 625 * LM);
        spacing("R3", "odd_field", od_n, od_last - od_prev, 625 * LM * 2);
        // progressive 525, long field
        scenario(1'b0, 1'b1, 1'b1, 263 * LM * 2 + 200);
        spacing("R4", "vdrive", vd_n, vd_last - vd_prev, 263 * LM * 2);
        // progressive 625, short field
        scenario(1'b1, 1'b1, 1'b0, 312 * LM * 2 + 200);
        spacing("R4", "vdrive", vd_n, vd_last - vd_prev, 312 * LM * 2);
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        mis++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

endmodule